// File: doc/BRIEF.md
# Serial Core State and Status Controller

This block is the control and status front end of a serial master core. A run-state machine decides whether the protocol engine may run. It has three states: idle/reset, running and paused. Each state change is followed by a one-cycle settling window, and the state-valid indication is low during that window. Around the state machine sit sticky status words. A transfer status word collects events from the protocol engine. An error word has a matching enable mask and drives an interrupt-style summary. An operational word shows the FIFO fill conditions and two service flags, one per FIFO direction.

Software reaches everything through a simple register port. The port takes one write or one read address per cycle, and read data is registered. The word map is:

| Address | Word |
|---|---|
| 0 | State (bits [1:0] code, bit 2 valid) |
| 1 | Software reset |
| 2 | Transfer status |
| 3 | Error flags |
| 4 | Error enables |
| 5 | Operational |

The protocol engine supplies event pulses. The FIFOs supply their fill levels. The block drives the current state, a run enable, a transfer-failure summary and an error interrupt.

Top module: `sctl_core`

## Requirements
- R1: After synchronous reset the state code is 2'b00 (idle/reset) with valid high, so the state word reads 32'h4. `run_en`, `xfer_fail` and `err_irq` are low, and every status word reads zero.
- R2: When the valid bit is high, a state-word write of code 2'b00, 2'b01 (run) or 2'b11 (pause) is accepted. The code appears on the next clock with valid low, and valid returns high one clock later. A state-word write made while valid is low is ignored.
- R3: Some state-word writes are ignored and leave both state and valid unchanged: code 2'b10 outside pause, and code 2'b00 while in pause.
- R4: Pause can be left for idle/reset only by two writes of code 2'b10 to the state word with no other state-word write between them. A single such write leaves the block in pause with valid high. Any other accepted state-word write between the two cancels the first.
- R5: A write to the software reset word with bit 0 set forces code 2'b00 with valid low on the next clock, whatever the valid bit was. Valid returns one clock later. A write with bit 0 clear has no effect.
- R6: `run_en` is high exactly when the state code is 2'b01 and valid is high.
- R7: Transfer status bits 25..2 are set by `stat_evt` pulses and stay set. Writing 1 to a bit clears it, but a set in the same cycle wins over the clear. Bits 31..26, 1 and 0 always read zero.
- R8: `xfer_fail` goes high one clock after any of these transfer status bits is set, and stays high while one of them remains set: bus error (bit 2), arbitration lost (bit 3), failed (bit 4) and invalid read address (bit 5). Other status bits do not affect it.
- R9: Error flag bits 6..2 are set by `err_evt` pulses and cleared by writing 1. The error enable word holds written bits 6..2. All other bits of both words read zero.
- R10: `err_irq` is high one clock after any error flag bit and its enable bit are both set, and low otherwise.
- R11: The operational word shows the FIFO levels as read-only bits: output not empty (bit 0), output full (bit 1), input not empty (bit 2) and input full (bit 3). "Full" means the level equals `FIFO_DEPTH`.
- R12: The output service flag (operational bit 8) is set when output-not-empty changes from 1 to 0, and is cleared by writing 1 to bit 8. A rise of the output level does not set it.
- R13: The input service flag (operational bit 9) is set whenever the input level increases, and is cleared by writing 1 to bit 9. A fall of the input level does not set it.
- R14: Read data appears on `reg_rdata` one clock after the address is presented. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| stat_evt | input | 32 | Transfer status event pulses from the protocol engine |
| err_evt | input | 32 | Error event pulses |
| out_level | input | LVL_W | Output FIFO fill level |
| in_level | input | LVL_W | Input FIFO fill level |
| cur_state | output | 2 | Current state code |
| state_valid | output | 1 | State settled and ready to accept a change |
| run_en | output | 1 | Protocol engine may run |
| err_irq | output | 1 | Enabled error summary |
| xfer_fail | output | 1 | Transfer failure summary |

## Verification
The properties assume the register port carries at most one access per cycle, and that the level inputs never exceed `FIFO_DEPTH`. They also assume the inputs are quiet while reset is high. The state properties further rely on the state word being written only through `reg_wr`, with the code in `reg_wdata[1:0]`. The bench honours these assumptions. It changes every input only on the falling clock edge and issues one write or one read address at a time. It holds both levels and all event pulses at zero through reset, and keeps the levels between 0 and `FIFO_DEPTH`.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [1:0] ST_RESET = 2'b00;
  localparam logic [1:0] ST_RUN   = 2'b01;
  localparam logic [1:0] ST_PAUSE = 2'b11;
  localparam logic [1:0] ST_CLEAR = 2'b10;

  localparam logic [ADDR_W-1:0] A_STATE = 3'd0;
  localparam logic [ADDR_W-1:0] A_SWRST = 3'd1;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERRFL = 3'd3;
  localparam logic [ADDR_W-1:0] A_ERREN = 3'd4;
  localparam logic [ADDR_W-1:0] A_OPER  = 3'd5;

  localparam int B_BUS_ERR  = 2;
  localparam int B_ARB_LOST = 3;
  localparam int B_FAILED   = 4;
  localparam int B_INV_RD   = 5;

  localparam int B_OUT_SVC = 8;
  localparam int B_IN_SVC  = 9;

  function automatic logic [DATA_W-1:0] span_mask(int lo, int hi);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] MSTAT_MASK = span_mask(2, 25);
  localparam logic [DATA_W-1:0] ERR_MASK   = span_mask(2, 6);
  localparam logic [DATA_W-1:0] FAIL_MASK  = span_mask(B_BUS_ERR, B_INV_RD);
endpackage

// File: rtl/sctl_state_fsm.sv
module sctl_state_fsm
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       st_wr,
  input  logic [1:0] st_code,
  input  logic       sw_rst,
  output logic [1:0] state_o,
  output logic       valid_o,
  output logic       run_en_o
);
  logic [1:0] state_q, state_d;
  logic       valid_q, valid_d;
  logic       arm_q, arm_d;
  logic       run_q;

  always_comb begin
    state_d = state_q;
    valid_d = 1'b1;
    arm_d   = arm_q;
    if (sw_rst) begin
      state_d = ST_RESET;
      valid_d = 1'b0;
      arm_d   = 1'b0;
    end else if (st_wr && valid_q) begin
      arm_d = 1'b0;
      case (st_code)
        ST_RESET: begin
          if (state_q != ST_PAUSE) begin
            state_d = ST_RESET;
            valid_d = 1'b0;
          end
        end
        ST_RUN, ST_PAUSE: begin
          state_d = st_code;
          valid_d = 1'b0;
        end
        default: begin
          if (state_q == ST_PAUSE) begin
            if (arm_q) begin
              state_d = ST_RESET;
              valid_d = 1'b0;
            end else begin
              arm_d = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RESET;
      valid_q <= 1'b1;
      arm_q   <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      arm_q   <= arm_d;
      run_q   <= (state_d == ST_RUN) && valid_d;
    end
  end

  assign state_o  = state_q;
  assign valid_o  = valid_q;
  assign run_en_o = run_q;
endmodule

// File: rtl/sctl_w1c_reg.sv
module sctl_w1c_reg #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((q & ~clr_i) | set_i) & MASK;
  end

  assign q_o = q;
endmodule

// File: rtl/sctl_fifo_watch.sv
module sctl_fifo_watch #(
  parameter  int FIFO_DEPTH = 16,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] out_level,
  input  logic [LVL_W-1:0] in_level,
  output logic [3:0]       lvl_bits,
  output logic             out_drain,
  output logic             in_arrive
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic             out_ne_q;
  logic [LVL_W-1:0] in_lvl_q;
  logic             out_ne;

  assign out_ne   = out_level != '0;
  assign lvl_bits = {in_level == FULL_LVL, in_level != '0,
                     out_level == FULL_LVL, out_ne};
  assign out_drain = out_ne_q && !out_ne;
  assign in_arrive = in_level > in_lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ne_q <= 1'b0;
      in_lvl_q <= '0;
    end else begin
      out_ne_q <= out_ne;
      in_lvl_q <= in_level;
    end
  end
endmodule

// File: rtl/sctl_core.sv
module sctl_core
  import sctl_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] stat_evt,
  input  logic [DATA_W-1:0] err_evt,
  input  logic [LVL_W-1:0]  out_level,
  input  logic [LVL_W-1:0]  in_level,
  output logic [1:0]        cur_state,
  output logic              state_valid,
  output logic              run_en,
  output logic              err_irq,
  output logic              xfer_fail
);
  logic wr_state, wr_swrst, wr_mstat, wr_errfl, wr_erren, wr_oper;
  assign wr_state = reg_wr && (reg_addr == A_STATE);
  assign wr_swrst = reg_wr && (reg_addr == A_SWRST);
  assign wr_mstat = reg_wr && (reg_addr == A_MSTAT);
  assign wr_errfl = reg_wr && (reg_addr == A_ERRFL);
  assign wr_erren = reg_wr && (reg_addr == A_ERREN);
  assign wr_oper  = reg_wr && (reg_addr == A_OPER);

  sctl_state_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .st_wr    (wr_state),
    .st_code  (reg_wdata[1:0]),
    .sw_rst   (wr_swrst && reg_wdata[0]),
    .state_o  (cur_state),
    .valid_o  (state_valid),
    .run_en_o (run_en)
  );

  logic [DATA_W-1:0] mstat_q, errfl_q;
  logic [1:0]        svc_q;

  sctl_w1c_reg #(.W(DATA_W), .MASK(MSTAT_MASK)) u_mstat (
    .clk   (clk),
    .rst   (rst),
    .set_i (stat_evt),
    .clr_i (wr_mstat ? reg_wdata : '0),
    .q_o   (mstat_q)
  );

  sctl_w1c_reg #(.W(DATA_W), .MASK(ERR_MASK)) u_errfl (
    .clk   (clk),
    .rst   (rst),
    .set_i (err_evt),
    .clr_i (wr_errfl ? reg_wdata : '0),
    .q_o   (errfl_q)
  );

  logic [3:0] lvl_bits;
  logic       out_drain, in_arrive;

  sctl_fifo_watch #(.FIFO_DEPTH(FIFO_DEPTH)) u_watch (
    .clk       (clk),
    .rst       (rst),
    .out_level (out_level),
    .in_level  (in_level),
    .lvl_bits  (lvl_bits),
    .out_drain (out_drain),
    .in_arrive (in_arrive)
  );

  sctl_w1c_reg #(.W(2), .MASK(2'b11)) u_svc (
    .clk   (clk),
    .rst   (rst),
    .set_i ({in_arrive, out_drain}),
    .clr_i (wr_oper ? reg_wdata[B_IN_SVC:B_OUT_SVC] : 2'b00),
    .q_o   (svc_q)
  );

  logic [DATA_W-1:0] erren_q;
  logic              irq_q, fail_q;
  logic [DATA_W-1:0] oper_word;

  always_comb begin
    oper_word = '0;
    oper_word[3:0] = lvl_bits;
    oper_word[B_IN_SVC:B_OUT_SVC] = svc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      erren_q   <= '0;
      irq_q     <= 1'b0;
      fail_q    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_erren) erren_q <= reg_wdata & ERR_MASK;
      irq_q  <= |(errfl_q & erren_q);
      fail_q <= |(mstat_q & FAIL_MASK);
      case (reg_addr)
        A_STATE: reg_rdata <= {{(DATA_W-3){1'b0}}, state_valid, cur_state};
        A_MSTAT: reg_rdata <= mstat_q;
        A_ERRFL: reg_rdata <= errfl_q;
        A_ERREN: reg_rdata <= erren_q;
        A_OPER:  reg_rdata <= oper_word;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign err_irq   = irq_q;
  assign xfer_fail = fail_q;
endmodule

// File: rtl/sctl_core_chk.sv
module sctl_core_chk
  import sctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [1:0]        cur_state,
  input logic              state_valid,
  input logic              run_en,
  input logic              xfer_fail
);
  logic st_wr, mstat_wr;
  assign st_wr    = reg_wr && (reg_addr == A_STATE);
  assign mstat_wr = reg_wr && (reg_addr == A_MSTAT);

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_wr && !state_valid) |=> $stable(cur_state)); // R2
  AST_VALID_DIP_SHORT: assert property (@(posedge clk) disable iff (rst)
    !state_valid |=> state_valid); // R2
  AST_PAUSE_NO_DIRECT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (st_wr && reg_wdata[1:0] == ST_RESET && cur_state == ST_PAUSE && state_valid)
      |=> (cur_state == ST_PAUSE)); // R3
  AST_SWRST_FORCES_RESET: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_SWRST && reg_wdata[0])
      |=> (cur_state == ST_RESET && !state_valid)); // R5
  AST_RUN_EN_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    run_en == (cur_state == ST_RUN && state_valid)); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (xfer_fail && !mstat_wr && !$past(mstat_wr)) |=> xfer_fail); // R8
endmodule

bind sctl_core sctl_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .cur_state   (cur_state),
  .state_valid (state_valid),
  .run_en      (run_en),
  .xfer_fail   (xfer_fail)
);

// File: tb/sctl_core_tb.sv
`timescale 1ns/1ps
module sctl_core_tb;
  import sctl_pkg::*;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [DATA_W-1:0] stat_evt = '0;
  logic [DATA_W-1:0] err_evt = '0;
  logic [LW-1:0]     out_level = '0;
  logic [LW-1:0]     in_level = '0;
  logic [1:0]        cur_state;
  logic              state_valid, run_en, err_irq, xfer_fail;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sctl_core #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_evt(stat_evt),
    .err_evt(err_evt), .out_level(out_level), .in_level(in_level),
    .cur_state(cur_state), .state_valid(state_valid), .run_en(run_en),
    .err_irq(err_irq), .xfer_fail(xfer_fail)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic st(string req, logic [1:0] s, logic v);
    chk({req, " state"}, {30'd0, cur_state}, {30'd0, s});
    chk({req, " valid"}, {31'd0, state_valid}, {31'd0, v});
  endtask

  task automatic go(logic [1:0] s);
    wr(A_STATE, {30'd0, s});
    idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    st("R1", ST_RESET, 1'b1);
    chk("R1 run_en", {31'd0, run_en}, 0);
    chk("R1 err_irq", {31'd0, err_irq}, 0);
    chk("R1 xfer_fail", {31'd0, xfer_fail}, 0);
    rd(A_STATE, d); chk("R1 state word", d, 32'h4);
    rd(A_MSTAT, d); chk("R1 mstat", d, 0);
    rd(A_OPER, d);  chk("R1 oper", d, 0);
  endtask

  task automatic t_transitions();
    wr(A_STATE, 32'h1);
    st("R2 accept", ST_RUN, 1'b0);
    chk("R6 run_en settling", {31'd0, run_en}, 0);
    wr(A_STATE, 32'h3); // made while valid is low
    st("R2 busy ignored", ST_RUN, 1'b1);
    chk("R6 run_en running", {31'd0, run_en}, 1);
    go(ST_PAUSE);
    st("R2 pause", ST_PAUSE, 1'b1);
    chk("R6 run_en paused", {31'd0, run_en}, 0);
  endtask

  task automatic t_undefined();
    wr(A_SWRST, 32'h1); idle(1);
    wr(A_STATE, 32'h2);
    st("R3 clear in reset", ST_RESET, 1'b1);
    go(ST_RUN);
    wr(A_STATE, 32'h2);
    st("R3 clear in run", ST_RUN, 1'b1);
    go(ST_PAUSE);
    wr(A_STATE, 32'h0);
    st("R3 reset code in pause", ST_PAUSE, 1'b1);
  endtask

  task automatic t_pause_exit();
    wr(A_STATE, 32'h2);
    st("R4 single clear", ST_PAUSE, 1'b1);
    idle(2);
    wr(A_STATE, 32'h2);
    st("R4 second clear", ST_RESET, 1'b0);
    idle(1);
    go(ST_PAUSE);
    wr(A_STATE, 32'h2);
    go(ST_PAUSE);            // cancels the armed clear
    wr(A_STATE, 32'h2);
    st("R4 cancelled", ST_PAUSE, 1'b1);
    wr(A_STATE, 32'h2);
    st("R4 completes", ST_RESET, 1'b0);
    idle(1);
  endtask

  task automatic t_swrst();
    go(ST_RUN);
    wr(A_SWRST, 32'h0);
    st("R5 bit0 clear", ST_RUN, 1'b1);
    wr(A_SWRST, 32'h1);
    st("R5 forced", ST_RESET, 1'b0);
    chk("R6 run_en after swrst", {31'd0, run_en}, 0);
    idle(1);
    st("R5 settled", ST_RESET, 1'b1);
  endtask

  task automatic t_mstat();
    logic [31:0] d;
    stat_evt = 32'h400; @(negedge clk); stat_evt = '0;
    idle(1);
    chk("R8 non-fail bit", {31'd0, xfer_fail}, 0);
    rd(A_MSTAT, d); chk("R7 single bit", d, 32'h400);
    stat_evt = 32'hFFFF_FFFF; @(negedge clk); stat_evt = '0;
    idle(1);
    chk("R8 fail set", {31'd0, xfer_fail}, 1);
    rd(A_MSTAT, d); chk("R7 reserved zero", d, 32'h03FF_FFFC);
    wr(A_MSTAT, 32'h400);
    rd(A_MSTAT, d); chk("R7 w1c one bit", d, 32'h03FF_FBFC);
    wr(A_MSTAT, 32'hFFFF_FFFF);
    idle(1);
    rd(A_MSTAT, d); chk("R7 w1c all", d, 0);
    chk("R8 fail cleared", {31'd0, xfer_fail}, 0);
    stat_evt = 32'h8; reg_wr = 1'b1; reg_addr = A_MSTAT; reg_wdata = 32'h8;
    @(negedge clk);
    stat_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    idle(1);
    chk("R8 arb lost", {31'd0, xfer_fail}, 1);
    rd(A_MSTAT, d); chk("R7 set beats clear", d, 32'h8);
    wr(A_MSTAT, 32'h8);
    idle(1);
  endtask

  task automatic t_err();
    logic [31:0] d;
    wr(A_ERREN, 32'hFFFF_FFFF);
    rd(A_ERREN, d); chk("R9 enable mask", d, 32'h7C);
    wr(A_ERREN, 32'h0);
    err_evt = 32'hFFFF_FFFF; @(negedge clk); err_evt = '0;
    idle(1);
    chk("R10 no enable", {31'd0, err_irq}, 0);
    rd(A_ERRFL, d); chk("R9 flags", d, 32'h7C);
    wr(A_ERREN, 32'h8);
    idle(1);
    chk("R10 enabled", {31'd0, err_irq}, 1);
    wr(A_ERRFL, 32'h8);
    idle(1);
    chk("R10 flag cleared", {31'd0, err_irq}, 0);
    rd(A_ERRFL, d); chk("R9 w1c", d, 32'h74);
  endtask

  task automatic t_oper();
    logic [31:0] d;
    out_level = LW'(DEPTH);
    rd(A_OPER, d); chk("R11 out full", d, 32'h3);
    out_level = 5;
    rd(A_OPER, d); chk("R11 out partial", d, 32'h1);
    out_level = 0;
    rd(A_OPER, d); chk("R12 drain sets svc", d, 32'h100);
    wr(A_OPER, 32'h100);
    rd(A_OPER, d); chk("R12 w1c", d, 32'h0);
    out_level = 3;
    rd(A_OPER, d); chk("R12 rise no svc", d, 32'h1);
    out_level = 0; idle(1); wr(A_OPER, 32'h100);
    in_level = 1;
    rd(A_OPER, d); chk("R13 arrive", d, 32'h204);
    in_level = LW'(DEPTH);
    rd(A_OPER, d); chk("R11 in full", d, 32'h20C);
    wr(A_OPER, 32'h200);
    in_level = LW'(DEPTH - 1);
    rd(A_OPER, d); chk("R13 fall no svc", d, 32'h4);
    in_level = 0; idle(1); wr(A_OPER, 32'h200);
  endtask

  task automatic t_read_map();
    logic [31:0] d;
    rd(3'd6, d); chk("R14 addr6", d, 0);
    rd(3'd7, d); chk("R14 addr7", d, 0);
    go(ST_RUN);
    reg_addr = A_STATE;
    @(posedge clk); #1;
    chk("R14 one-cycle latency", reg_rdata, 32'h5);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_transitions();
    t_undefined();
    t_pause_exit();
    t_swrst();
    t_mstat();
    t_err();
    t_oper();
    t_read_map();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule